// File: doc/BRIEF.md
# Phase-Domain Digital PLL Core

This block is a sampled phase-locked loop that works entirely on phase words. The reference phase arrives on every sample strobe as an unsigned fraction of a cycle. The core subtracts its own oscillator phase from that word and reads the difference as a signed value. This folds the error into the interval from minus half a cycle to just under plus half a cycle.

The error drives a proportional-plus-integral filter whose gains are run-time right-shift amounts. The integrator is saturating and reaches the output one sample late. The filter correction is clamped to a signed phase-word range and added to a nominal frequency word. The sum steps a wrapping phase accumulator.

A lock flag rises once the error magnitude has stayed below a programmable threshold for a run of consecutive samples. It drops on the first sample that misses. All state moves only on samples, and every output is registered, one clock after the strobe.

Top module: `dpll_core`

## Requirements
- R1: While rst_ni is low, nco_phase_o, phase_err_o, fcw_o and lock_o are all zero, and the integrator is cleared.
- R2: On each sample, phase_err_o becomes (ref_phase_i - nco_phase_o) modulo 2^16, read as a two's-complement value. An oscillator phase of 0x9000 against reference 0x0000 gives 0x7000. Against reference 0x1000 it gives 0x8000, which is minus half a cycle.
- R3: On each sample, nco_phase_o becomes its previous value plus the new fcw_o, modulo 2^16.
- R4: On each sample, fcw_o becomes nom_fcw_i plus the correction, modulo 2^16. The correction is the arithmetic right shift of the signed error by kp_shift_i, added to the integrator value held before this sample.
- R5: The integrator adds the error shifted arithmetically right by ki_shift_i on each sample. The new value first reaches fcw_o on the following sample. From reset, with kp_shift_i=15, a nominal word of 0 and a constant error of 1000, fcw_o is 0 and then 1000.
- R6: The integrator is a 32-bit signed register that saturates at its two limits instead of wrapping.
- R7: lock_o goes high on the 64th consecutive sample whose absolute error is strictly below lock_thresh_i. It is low on the 63rd.
- R8: lock_o goes low on the first sample whose absolute error is at or above lock_thresh_i. A sample whose error equals the threshold counts as a miss.
- R9: When sample_valid_i is low, no output changes, whatever the other inputs do.
- R10: The correction is clamped to the range -32768 to 32767 before it is added to nom_fcw_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Sample strobe; all state updates only on cycles where it is high |
| ref_phase_i | input | 16 | Reference phase, unsigned fraction of a cycle |
| nom_fcw_i | input | 16 | Nominal frequency word, cycles per sample |
| kp_shift_i | input | 4 | Proportional gain as a right-shift amount |
| ki_shift_i | input | 4 | Integral gain as a right-shift amount |
| lock_thresh_i | input | 16 | Absolute error limit for lock |
| nco_phase_o | output | 16 | Oscillator phase |
| phase_err_o | output | 16 | Wrapped phase error, two's complement |
| fcw_o | output | 16 | Frequency control word applied on the last sample |
| lock_o | output | 1 | Lock flag |

## Verification
The main path is exercised in four ways, each compared against a model computed in the bench.

A table of mixed reference, nominal-word and gain settings checks the error, frequency word and phase arithmetic together. Directed wrap cases place the oscillator phase more than half a cycle from the reference, and exactly half a cycle from it. These separate a signed fold of the difference from an unsigned one.

A reference that stays a fixed offset ahead of the oscillator isolates the lock counter. It shows the 63rd and 64th samples and the drop when the error equals the threshold. A long run holding the error near plus half a cycle drives the integrator into its upper limit. A wrapping integrator would show up there as a frequency word flipping to the negative clamp. A final step with the strobe low and the inputs changed shows that nothing moves.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  typedef enum logic {
    LK_SEARCH = 1'b0,
    LK_HOLD   = 1'b1
  } lock_state_e;
endpackage

// File: rtl/dpll_phase_det.sv
module dpll_phase_det #(
  parameter int unsigned PHASE_W = 16
) (
  input  logic [PHASE_W-1:0] ref_i,
  input  logic [PHASE_W-1:0] nco_i,
  output logic [PHASE_W-1:0] err_o,
  output logic [PHASE_W:0]   mag_o
);
  // modulo difference read as signed folds into +/- half cycle
  assign err_o = ref_i - nco_i;
  assign mag_o = err_o[PHASE_W-1] ? (~{1'b1, err_o}) + 1'b1 : {1'b0, err_o};
endmodule

// File: rtl/dpll_pi_filter.sv
module dpll_pi_filter #(
  parameter int unsigned PHASE_W = 16,
  parameter int unsigned INT_W   = 32,
  parameter int unsigned SHIFT_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PHASE_W-1:0] err_i,
  input  logic [SHIFT_W-1:0] kp_sh_i,
  input  logic [SHIFT_W-1:0] ki_sh_i,
  output logic [PHASE_W-1:0] corr_o
);
  localparam int unsigned EXT_W = INT_W - PHASE_W;
  localparam logic signed [INT_W:0] CMAX =
    $signed({{(INT_W-PHASE_W+2){1'b0}}, {(PHASE_W-1){1'b1}}});
  localparam logic signed [INT_W:0] CMIN = -CMAX - 1;

  logic [INT_W-1:0]          integ_q, integ_d, inc;
  logic [INT_W:0]            sum;
  logic signed [PHASE_W-1:0] prop, ish;
  logic signed [INT_W:0]     total;

  assign prop = $signed(err_i) >>> kp_sh_i;
  assign ish  = $signed(err_i) >>> ki_sh_i;
  assign inc  = {{EXT_W{ish[PHASE_W-1]}}, ish};
  assign sum  = {integ_q[INT_W-1], integ_q} + {inc[INT_W-1], inc};

  always_comb begin
    if (sum[INT_W] != sum[INT_W-1])
      integ_d = sum[INT_W] ? {1'b1, {(INT_W-1){1'b0}}} : {1'b0, {(INT_W-1){1'b1}}};
    else
      integ_d = sum[INT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   integ_q <= '0;
    else if (en_i) integ_q <= integ_d;
  end

  // integrator term is the pre-sample value: one-sample delay
  assign total = $signed({integ_q[INT_W-1], integ_q}) +
                 $signed({{(INT_W+1-PHASE_W){prop[PHASE_W-1]}}, prop});

  always_comb begin
    if (total > CMAX)      corr_o = CMAX[PHASE_W-1:0];
    else if (total < CMIN) corr_o = CMIN[PHASE_W-1:0];
    else                   corr_o = total[PHASE_W-1:0];
  end

  // R6
  integ_sat_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !integ_q[INT_W-1] && !inc[INT_W-1] |=> !integ_q[INT_W-1]);
  // R6
  integ_sat_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && integ_q[INT_W-1] && inc[INT_W-1] |=> integ_q[INT_W-1]);
endmodule

// File: rtl/dpll_nco.sv
module dpll_nco #(
  parameter int unsigned PHASE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PHASE_W-1:0] nom_i,
  input  logic [PHASE_W-1:0] corr_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic [PHASE_W-1:0] fcw_o
);
  logic [PHASE_W-1:0] fcw_d;

  assign fcw_d = nom_i + corr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= '0;
      fcw_o   <= '0;
    end else if (en_i) begin
      phase_o <= phase_o + fcw_d;
      fcw_o   <= fcw_d;
    end
  end

  // R3
  phase_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> phase_o == $past(phase_o) + fcw_o);
endmodule

// File: rtl/dpll_lock_det.sv
module dpll_lock_det
  import dpll_pkg::*;
#(
  parameter int unsigned PHASE_W  = 16,
  parameter int unsigned LOCK_CNT = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PHASE_W:0]   mag_i,
  input  logic [PHASE_W-1:0] thresh_i,
  output logic               lock_o
);
  localparam int unsigned CNT_W = $clog2(LOCK_CNT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CNT - 1);

  lock_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             good;

  assign good   = mag_i < {1'b0, thresh_i};
  assign lock_o = (state_q == LK_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LK_SEARCH;
      cnt_q   <= '0;
    end else if (en_i) begin
      if (!good) begin
        state_q <= LK_SEARCH;
        cnt_q   <= '0;
      end else if (cnt_q == CNT_LAST) begin
        state_q <= LK_HOLD;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R8
  lock_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !good |=> !lock_o);
  // R7
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(en_i) && $past(cnt_q) == CNT_LAST);
endmodule

// File: rtl/dpll_core.sv
module dpll_core #(
  parameter int unsigned PHASE_W  = 16,
  parameter int unsigned INT_W    = 32,
  parameter int unsigned SHIFT_W  = 4,
  parameter int unsigned LOCK_CNT = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_valid_i,
  input  logic [PHASE_W-1:0] ref_phase_i,
  input  logic [PHASE_W-1:0] nom_fcw_i,
  input  logic [SHIFT_W-1:0] kp_shift_i,
  input  logic [SHIFT_W-1:0] ki_shift_i,
  input  logic [PHASE_W-1:0] lock_thresh_i,
  output logic [PHASE_W-1:0] nco_phase_o,
  output logic [PHASE_W-1:0] phase_err_o,
  output logic [PHASE_W-1:0] fcw_o,
  output logic               lock_o
);
  logic [PHASE_W-1:0] err, corr;
  logic [PHASE_W:0]   mag;

  dpll_phase_det #(.PHASE_W(PHASE_W)) u_pd (
    .ref_i (ref_phase_i),
    .nco_i (nco_phase_o),
    .err_o (err),
    .mag_o (mag)
  );

  dpll_pi_filter #(.PHASE_W(PHASE_W), .INT_W(INT_W), .SHIFT_W(SHIFT_W)) u_lf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (sample_valid_i),
    .err_i   (err),
    .kp_sh_i (kp_shift_i),
    .ki_sh_i (ki_shift_i),
    .corr_o  (corr)
  );

  dpll_nco #(.PHASE_W(PHASE_W)) u_nco (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (sample_valid_i),
    .nom_i   (nom_fcw_i),
    .corr_i  (corr),
    .phase_o (nco_phase_o),
    .fcw_o   (fcw_o)
  );

  dpll_lock_det #(.PHASE_W(PHASE_W), .LOCK_CNT(LOCK_CNT)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (sample_valid_i),
    .mag_i    (mag),
    .thresh_i (lock_thresh_i),
    .lock_o   (lock_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             phase_err_o <= '0;
    else if (sample_valid_i) phase_err_o <= err;
  end

  // R2
  err_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_i |=> phase_err_o == $past(ref_phase_i - nco_phase_o));
  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> $stable(nco_phase_o) && $stable(phase_err_o) &&
                        $stable(fcw_o) && $stable(lock_o));
endmodule

// File: tb/dpll_core_tb.sv
module dpll_core_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sample_valid_i = 1'b0;
  logic [15:0] ref_phase_i = '0, nom_fcw_i = '0, lock_thresh_i = '0;
  logic [3:0]  kp_shift_i = '0, ki_shift_i = '0;
  logic [15:0] nco_phase_o, phase_err_o, fcw_o;
  logic        lock_o;

  int total = 0, bad = 0;
  int mph, mcnt, mlock;
  longint minteg;

  typedef struct packed {
    logic [15:0] rf;
    logic [15:0] nom;
    logic [3:0]  kp;
    logic [3:0]  ki;
    logic [15:0] thr;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'h0100, 16'h0400, 4'd2,  4'd6,  16'h0200},
    '{16'h4000, 16'h0400, 4'd2,  4'd6,  16'h0200},
    '{16'hC000, 16'h0010, 4'd0,  4'd3,  16'h1000},
    '{16'h7FFF, 16'h8000, 4'd1,  4'd0,  16'h0000},
    '{16'h0000, 16'hFFF0, 4'd4,  4'd8,  16'hFFFF},
    '{16'h1234, 16'h0001, 4'd15, 4'd15, 16'h0100},
    '{16'hFEDC, 16'h2000, 4'd3,  4'd1,  16'h8000},
    '{16'h8000, 16'h0000, 4'd0,  4'd0,  16'h0010}
  };

  always #4 clk_i = ~clk_i;

  dpll_core dut_i (
    .clk_i, .rst_ni, .sample_valid_i, .ref_phase_i, .nom_fcw_i,
    .kp_shift_i, .ki_shift_i, .lock_thresh_i,
    .nco_phase_o, .phase_err_o, .fcw_o, .lock_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    sample_valid_i = 1'b0;
    rst_ni = 1'b0;
    mph = 0; mcnt = 0; mlock = 0; minteg = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // one sample; leaves the strobe high
  task automatic step(input logic [15:0] rf, input logic [15:0] nom,
                      input logic [3:0] kp, input logic [3:0] ki,
                      input logic [15:0] thr);
    int e, se, prop, corr, fcw, mag;
    longint tot;
    ref_phase_i = rf; nom_fcw_i = nom; kp_shift_i = kp;
    ki_shift_i = ki; lock_thresh_i = thr;
    sample_valid_i = 1'b1;
    e  = (int'(rf) - mph) & 32'hFFFF;
    se = (e >= 32768) ? e - 65536 : e;
    prop = se >>> kp;
    tot = minteg + longint'(prop);
    if (tot > 32767)       corr = 32767;
    else if (tot < -32768) corr = -32768;
    else                   corr = int'(tot);
    fcw = (int'(nom) + corr) & 32'hFFFF;
    mph = (mph + fcw) & 32'hFFFF;
    minteg = minteg + longint'(se >>> ki);
    if (minteg > 64'sd2147483647)  minteg = 64'sd2147483647;
    if (minteg < -64'sd2147483648) minteg = -64'sd2147483648;
    mag = (se < 0) ? -se : se;
    if (mag < int'(thr)) begin
      if (mcnt >= 63) mlock = 1;
      else mcnt++;
    end else begin
      mcnt = 0; mlock = 0;
    end
    @(negedge clk_i);
    chk("R2 err", int'(phase_err_o), e);
    chk("R4 fcw", int'(fcw_o), fcw);
    chk("R3 phase", int'(nco_phase_o), mph);
    chk("R7 lock", int'(lock_o), mlock);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog act=expired exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] hp, he, hf;
    logic        hl;

    // R1 reset state
    mph = 0; mcnt = 0; mlock = 0; minteg = 0;
    repeat (2) @(negedge clk_i);
    chk("R1 phase", int'(nco_phase_o), 0);
    chk("R1 err", int'(phase_err_o), 0);
    chk("R1 fcw", int'(fcw_o), 0);
    chk("R1 lock", int'(lock_o), 0);
    rst_ni = 1'b1;

    // table walk
    for (int n = 0; n < 3; n++)
      for (int i = 0; i < 8; i++)
        step(VECS[i].rf, VECS[i].nom, VECS[i].kp, VECS[i].ki, VECS[i].thr);

    // R1 reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    sample_valid_i = 1'b0;
    #1;
    chk("R1 async phase", int'(nco_phase_o), 0);
    chk("R1 async fcw", int'(fcw_o), 0);

    // R5 one-sample integrator delay
    do_reset();
    step(16'd1000, 16'd0, 4'd15, 4'd0, 16'd0);
    chk("R5 first fcw", int'(fcw_o), 0);
    step(16'd1000, 16'd0, 4'd15, 4'd0, 16'd0);
    chk("R5 second fcw", int'(fcw_o), 1000);

    // R2 half-cycle wrap
    do_reset();
    step(16'h0000, 16'h9000, 4'd15, 4'd15, 16'd0);
    step(16'h0000, 16'h0000, 4'd15, 4'd15, 16'd0);
    chk("R2 wrap pos", int'(phase_err_o), 16'h7000);
    step(16'h1000, 16'h0000, 4'd15, 4'd15, 16'd0);
    chk("R2 half cycle", int'(phase_err_o), 16'h8000);

    // R7 / R8 lock
    do_reset();
    for (int k = 0; k < 63; k++)
      step(16'((mph + 10) & 16'hFFFF), 16'h0100, 4'd15, 4'd15, 16'd100);
    chk("R7 not at 63", int'(lock_o), 0);
    step(16'((mph + 10) & 16'hFFFF), 16'h0100, 4'd15, 4'd15, 16'd100);
    chk("R7 at 64", int'(lock_o), 1);
    step(16'((mph - 20) & 16'hFFFF), 16'h0100, 4'd15, 4'd15, 16'd100);
    chk("R7 held", int'(lock_o), 1);
    step(16'((mph + 100) & 16'hFFFF), 16'h0100, 4'd15, 4'd15, 16'd100);
    chk("R8 drop at thr", int'(lock_o), 0);

    // R9 idle
    @(negedge clk_i);
    sample_valid_i = 1'b0;
    hp = nco_phase_o; he = phase_err_o; hf = fcw_o; hl = lock_o;
    ref_phase_i = 16'h5555; nom_fcw_i = 16'h3333; kp_shift_i = 4'd0;
    repeat (3) @(negedge clk_i);
    chk("R9 phase", int'(nco_phase_o), int'(hp));
    chk("R9 err", int'(phase_err_o), int'(he));
    chk("R9 fcw", int'(fcw_o), int'(hf));
    chk("R9 lock", int'(lock_o), int'(hl));

    // R6 / R10 integrator saturation and correction clamp
    do_reset();
    step(16'((mph + 16'h7FFF) & 16'hFFFF), 16'h0040, 4'd15, 4'd0, 16'd0);
    step(16'((mph + 16'h7FFF) & 16'hFFFF), 16'h0040, 4'd15, 4'd0, 16'd0);
    step(16'((mph + 16'h7FFF) & 16'hFFFF), 16'h0040, 4'd15, 4'd0, 16'd0);
    chk("R10 clamp", int'(fcw_o), (16'h0040 + 32767) & 16'hFFFF);
    for (int k = 0; k < 65600; k++)
      step(16'((mph + 16'h7FFF) & 16'hFFFF), 16'h0040, 4'd15, 4'd0, 16'd0);
    step(16'((mph - 16'h4000) & 16'hFFFF), 16'h0040, 4'd0, 4'd0, 16'd0);
    chk("R6 sat hold", int'(fcw_o), (16'h0040 + 32767) & 16'hFFFF);

    @(negedge clk_i);
    sample_valid_i = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule